// File: doc/BRIEF.md
# Multi-Mode Prescaled Compare Timer

The block is a register-controlled timer. An 8-bit prescaler divides the clock by (prescale + 1), and each resulting step advances a 24-bit up counter. The counter is compared with a programmable match value. On a match, the block sets a sticky time-out flag. What happens to the counter after a match depends on which of four end-of-count behaviours is selected: stop after one period, restart, restart and invert an output pin, or keep running.

Software controls the timer through a simple write port and a combinational read port. There are four word registers: control, match, status and count. The interrupt output is the time-out flag gated by an enable bit.

The sequencing is held in a three-state machine:
- `ST_IDLE`: stopped with the counter cleared.
- `ST_RUN`: counting.
- `ST_HALT`: suspended, keeping the held count.

The transitions are:
- start (`ST_IDLE`/`ST_HALT` → `ST_RUN`) on a control write with the run bit set.
- suspend (`ST_RUN` → `ST_HALT`) on a control write with the run bit clear.
- finish (`ST_RUN` → `ST_IDLE`) on a match in one-shot mode.
- purge (any state → `ST_IDLE`) on a control write with the clear bit set.

Top module: `cmp_timer_top`

## Requirements
- R1: After reset every register reads 0, and `timeout_o`, `irq_o`, `toggle_o` and `active_o` are 0.
- R2: Register map (word address on `wr_addr`/`rd_addr`):
  - 0 is control: bits [7:0] prescale, [9:8] mode, [10] interrupt enable, [11] run (reads the live state), [12] clear action (reads 0), [13] active (read-only), [14] toggle level (read-only).
  - 1 is match, bits [23:0].
  - 2 is status, bit [0] is the time-out flag.
  - 3 is count, bits [23:0], read-only.
  - The writable fields read back what was written.
- R3: While running, the counter advances once every (prescale + 1) clocks. The time-out flag sets on the step on which the counter would reach the match value, so one period is (prescale + 1) × match clocks.
- R4: Mode 00 (one-shot): a match sets the flag, zeroes the counter and clears the run bit, so counting stops.
- R5: Mode 01 (periodic): a match sets the flag, zeroes the counter, and counting carries on.
- R6: Mode 10 (toggle): `toggle_o` inverts on every match, and the counter restarts as in periodic mode.
- R7: Mode 11 (continuous): a match sets the flag without zeroing the counter, which keeps counting and wraps modulo 2^24.
- R8: A control write with run = 0 suspends counting with the count held. A later write with run = 1 resumes from the held value.
- R9: A write to the match register restarts the counter and the prescaler from 0 in modes 00, 01 and 10. In mode 11 such a write leaves the count undisturbed.
- R10: A control write with the clear bit set zeroes the prescaler, the counter and the run bit, whatever run value the same write carries.
- R11: Writing 1 to status bit 0 clears the time-out flag. `irq_o` is 1 exactly when the flag and the interrupt-enable bit are both 1.
- R12: A match value of 0 or 1 behaves as a match value of 2.
- R13: `active_o` and control bit 13 are 1 exactly while the timer is counting (run bit set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the timer's count tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |
| timeout_o | output | 1 | Sticky time-out flag |
| irq_o | output | 1 | Time-out flag gated by the interrupt enable |
| toggle_o | output | 1 | Toggle-mode output level |
| active_o | output | 1 | Counter running |

## Verification
The checker assumes that a control write never coincides with a match in one-shot or periodic mode. Under that assumption, a hardware stop or restart is never overridden by a software run value in the same cycle.

It also assumes that the mode field is not changed while the counter is beyond the match value. The stimulus respects both assumptions. Every scenario, random or directed, starts with a clear-action write, a flag clear and a match write made while the timer is stopped, and only then is the run write issued. Mid-run writes are limited to match writes, run toggles and clear actions, each placed well away from a match.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    localparam int PSC_W  = 8;
    localparam int CNT_W  = 24;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_MATCH = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 2'd2;
    localparam logic [ADDR_W-1:0] A_COUNT = 2'd3;

    // control field positions
    localparam int B_MODE = PSC_W;       // two bits
    localparam int B_IEN  = PSC_W + 2;
    localparam int B_RUN  = PSC_W + 3;
    localparam int B_CLR  = PSC_W + 4;
    localparam int B_ACT  = PSC_W + 5;
    localparam int B_TOG  = PSC_W + 6;

    localparam int MIN_MATCH = 2;

    typedef enum logic [1:0] {
        MD_ONESHOT  = 2'b00,
        MD_PERIODIC = 2'b01,
        MD_TOGGLE   = 2'b10,
        MD_CONT     = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } state_e;

endpackage

// File: rtl/cmp_timer_presc.sv
module cmp_timer_presc
    import cmp_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [PSC_W-1:0] psc,
    output logic             step
);

    logic [PSC_W-1:0] div_q;

    // >= keeps a shrunken divisor from waiting for a full wrap
    always_comb begin
        step = en && (div_q >= psc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr) begin
            div_q <= '0;
        end else if (en) begin
            if (step) div_q <= '0;
            else      div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core
    import cmp_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode,
    input  logic [CNT_W-1:0] match,
    input  logic             step,
    input  logic             sw_clr,
    input  logic             run_set,
    input  logic             run_clr,
    input  logic             match_wr,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             hit,
    output logic             tog,
    output logic             psc_clr
);

    state_e           state_q, state_n;
    logic [CNT_W-1:0] eff_match;
    logic [CNT_W-1:0] cnt_inc;
    logic             restart_on_hit;
    logic             match_restart;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE, ST_HALT: begin
                if (sw_clr)       state_n = ST_IDLE;
                else if (run_set) state_n = ST_RUN;
            end
            ST_RUN: begin
                if (sw_clr)                            state_n = ST_IDLE;
                else if (run_clr)                      state_n = ST_HALT;
                else if (run_set)                      state_n = ST_RUN;
                else if (hit && (mode == MD_ONESHOT))  state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        running        = (state_q == ST_RUN);
        eff_match      = (match < CNT_W'(MIN_MATCH)) ? CNT_W'(MIN_MATCH) : match;
        cnt_inc        = cnt + 1'b1;
        hit            = step && (cnt_inc == eff_match);
        restart_on_hit = (mode != MD_CONT);
        match_restart  = match_wr && (mode != MD_CONT);
        psc_clr        = sw_clr || match_restart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (sw_clr || match_restart) begin
            cnt <= '0;
        end else if (hit && restart_on_hit) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog <= 1'b0;
        end else if (hit && (mode == MD_TOGGLE)) begin
            tog <= ~tog;
        end
    end

endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
    import cmp_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              hit,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              running,
    input  logic              tog,
    output logic [PSC_W-1:0]  psc,
    output mode_e             mode,
    output logic              irq_en,
    output logic [CNT_W-1:0]  match,
    output logic              flag,
    output logic              irq,
    output logic              sw_clr,
    output logic              run_set,
    output logic              run_clr,
    output logic              match_wr
);

    logic ctrl_wr;
    logic stat_wr;

    always_comb begin
        ctrl_wr  = wr_en && (wr_addr == A_CTRL);
        stat_wr  = wr_en && (wr_addr == A_STAT);
        match_wr = wr_en && (wr_addr == A_MATCH);
        sw_clr   = ctrl_wr && wr_data[B_CLR];
        run_set  = ctrl_wr && !wr_data[B_CLR] && wr_data[B_RUN];
        run_clr  = ctrl_wr && !wr_data[B_CLR] && !wr_data[B_RUN];
        irq      = flag && irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc    <= '0;
            mode   <= MD_ONESHOT;
            irq_en <= 1'b0;
        end else if (ctrl_wr) begin
            psc    <= wr_data[PSC_W-1:0];
            mode   <= mode_e'(wr_data[B_MODE+1:B_MODE]);
            irq_en <= wr_data[B_IEN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        match <= '0;
        else if (match_wr) match <= wr_data[CNT_W-1:0];
    end

    // hardware set wins over a same-cycle software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     flag <= 1'b0;
        else if (hit)                   flag <= 1'b1;
        else if (stat_wr && wr_data[0]) flag <= 1'b0;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL: begin
                rd_data[PSC_W-1:0]       = psc;
                rd_data[B_MODE+1:B_MODE] = mode;
                rd_data[B_IEN]           = irq_en;
                rd_data[B_RUN]           = running;
                rd_data[B_ACT]           = running;
                rd_data[B_TOG]           = tog;
            end
            A_MATCH: rd_data[CNT_W-1:0] = match;
            A_STAT:  rd_data[0]         = flag;
            A_COUNT: rd_data[CNT_W-1:0] = cnt;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cmp_timer_top.sv
module cmp_timer_top
    import cmp_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              timeout_o,
    output logic              irq_o,
    output logic              toggle_o,
    output logic              active_o
);

    logic [PSC_W-1:0] psc;
    mode_e            mode;
    logic             irq_en;
    logic [CNT_W-1:0] match;
    logic             flag;
    logic             irq;
    logic             sw_clr;
    logic             run_set;
    logic             run_clr;
    logic             match_wr;
    logic [CNT_W-1:0] cnt;
    logic             running;
    logic             hit;
    logic             tog;
    logic             psc_clr;
    logic             step;
    logic             ctrl_wr;

    cmp_timer_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .hit      (hit),
        .cnt      (cnt),
        .running  (running),
        .tog      (tog),
        .psc      (psc),
        .mode     (mode),
        .irq_en   (irq_en),
        .match    (match),
        .flag     (flag),
        .irq      (irq),
        .sw_clr   (sw_clr),
        .run_set  (run_set),
        .run_clr  (run_clr),
        .match_wr (match_wr)
    );

    cmp_timer_presc u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (running),
        .clr   (psc_clr),
        .psc   (psc),
        .step  (step)
    );

    cmp_timer_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .match    (match),
        .step     (step),
        .sw_clr   (sw_clr),
        .run_set  (run_set),
        .run_clr  (run_clr),
        .match_wr (match_wr),
        .cnt      (cnt),
        .running  (running),
        .hit      (hit),
        .tog      (tog),
        .psc_clr  (psc_clr)
    );

    always_comb begin
        ctrl_wr   = sw_clr || run_set || run_clr;
        timeout_o = flag;
        irq_o     = irq;
        toggle_o  = tog;
        active_o  = running;
    end

endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
    import cmp_timer_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             hit,
    input logic             sw_clr,
    input logic             ctrl_wr,
    input logic             match_wr,
    input logic [CNT_W-1:0] cnt,
    input logic             active,
    input logic             tog,
    input logic             flag,
    input logic             irq
);

    AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag); // R3

    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == 2'b00 && !ctrl_wr) |=> (!active && cnt == '0)); // R4

    AST_PERIODIC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == 2'b01 && !ctrl_wr && !match_wr) |=> (active && cnt == '0)); // R5

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == 2'b10) |=> (tog != $past(tog))); // R6

    AST_CONT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == 2'b11 && !sw_clr) |=> (cnt == $past(cnt) + 1'b1)); // R7

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !sw_clr && !match_wr) |=> $stable(cnt)); // R8

    AST_CLEAR_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> (cnt == '0 && !active)); // R10

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag); // R11

endmodule

bind cmp_timer_top cmp_timer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .hit      (hit),
    .sw_clr   (sw_clr),
    .ctrl_wr  (ctrl_wr),
    .match_wr (match_wr),
    .cnt      (cnt),
    .active   (active_o),
    .tog      (toggle_o),
    .flag     (timeout_o),
    .irq      (irq_o)
);

// File: tb/tb_cmp_timer_top.sv
module tb_cmp_timer_top;

    localparam int CLK_PERIOD = 10;
    localparam int B_IEN = 10;
    localparam int B_RUN = 11;
    localparam int B_CLR = 12;
    localparam int B_ACT = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        timeout_o, irq_o, toggle_o, active_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    cmp_timer_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .timeout_o(timeout_o), .irq_o(irq_o), .toggle_o(toggle_o),
        .active_o(active_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [31:0] ctl(int p, int md, bit ien, bit run, bit clr);
        logic [31:0] w = '0;
        w[7:0] = 8'(p);
        w[9:8] = 2'(md);
        w[B_IEN] = ien;
        w[B_RUN] = run;
        w[B_CLR] = clr;
        return w;
    endfunction

    function automatic int meff(int m);
        return (m < 2) ? 2 : m;
    endfunction

    function automatic int exp_cnt(int md, int p, int m, int n);
        int s = n / (p + 1);
        int e = meff(m);
        case (md)
            0:       return (s >= e) ? 0 : s;
            3:       return s;
            default: return s % e;
        endcase
    endfunction

    function automatic bit exp_flag(int p, int m, int n);
        return (n / (p + 1)) >= meff(m);
    endfunction

    // stop, clear flag, load match, then start
    task automatic start(int md, int p, int m, bit ien, output int t0);
        wr(2'd0, ctl(p, md, ien, 1'b0, 1'b1));
        wr(2'd2, 32'd1);
        wr(2'd1, 32'(m));
        wr(2'd0, ctl(p, md, ien, 1'b1, 1'b0));
        t0 = cyc;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int t0, t1, held, tg0;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reg", d, 32'h0);
        end
        chk("R1 outs", {28'h0, timeout_o, irq_o, toggle_o, active_o}, 32'h0);

        // R2 readback of writable fields
        wr(2'd0, ctl(5, 2, 1'b1, 1'b0, 1'b0));
        rd(2'd0, d);
        chk("R2 ctrl", d, ctl(5, 2, 1'b1, 1'b0, 1'b0));
        wr(2'd1, 32'h00ABCDEF);
        rd(2'd1, d);
        chk("R2 match", d, 32'h00ABCDEF);

        // R3 prescaled period, R5 periodic wrap, R11 irq
        start(1, 2, 4, 1'b1, t0);
        repeat (2) @(negedge clk);
        rd(2'd3, d); chk("R3 cnt n2", d, 32'(exp_cnt(1, 2, 4, cyc - t0)));
        @(negedge clk);
        rd(2'd3, d); chk("R3 cnt n3", d, 32'(exp_cnt(1, 2, 4, cyc - t0)));
        repeat (8) @(negedge clk);
        chk("R3 no flag before period", {31'h0, timeout_o}, 32'h0);
        @(negedge clk);
        rd(2'd3, d); chk("R5 wrap to 0", d, 32'h0);
        chk("R3 flag at period", {31'h0, timeout_o}, 32'h1);
        chk("R11 irq", {31'h0, irq_o}, 32'h1);
        chk("R5 still active", {31'h0, active_o}, 32'h1);
        wr(2'd2, 32'd1);
        chk("R11 w1c flag", {31'h0, timeout_o}, 32'h0);
        chk("R11 w1c irq", {31'h0, irq_o}, 32'h0);

        // R8 suspend and resume
        start(1, 0, 50, 1'b0, t0);
        repeat (7) @(negedge clk);
        wr(2'd0, ctl(0, 1, 1'b0, 1'b0, 1'b0));
        held = cyc - t0;
        rd(2'd3, d); chk("R8 held", d, 32'(held));
        repeat (5) @(negedge clk);
        rd(2'd3, d); chk("R8 stays held", d, 32'(held));
        chk("R13 inactive when held", {31'h0, active_o}, 32'h0);
        wr(2'd0, ctl(0, 1, 1'b0, 1'b1, 1'b0));
        t1 = cyc;
        repeat (4) @(negedge clk);
        rd(2'd3, d); chk("R8 resumed", d, 32'(held + cyc - t1));

        // R9 match write restarts in periodic
        start(1, 0, 30, 1'b0, t0);
        repeat (5) @(negedge clk);
        wr(2'd1, 32'd30);
        rd(2'd3, d); chk("R9 restart", d, 32'h0);
        repeat (3) @(negedge clk);
        rd(2'd3, d); chk("R9 recount", d, 32'd3);

        // R9 match write ignored in continuous
        start(3, 0, 30, 1'b0, t0);
        repeat (5) @(negedge clk);
        wr(2'd1, 32'd40);
        rd(2'd3, d); chk("R9 cont undisturbed", d, 32'(cyc - t0));

        // R7 continuous passes the match
        start(3, 0, 3, 1'b0, t0);
        repeat (9) @(negedge clk);
        rd(2'd3, d); chk("R7 past match", d, 32'(cyc - t0));
        chk("R7 flag", {31'h0, timeout_o}, 32'h1);

        // R10 clear action resets the prescaler too
        start(1, 3, 40, 1'b0, t0);
        repeat (10) @(negedge clk);
        wr(2'd0, ctl(3, 1, 1'b0, 1'b1, 1'b1));
        rd(2'd3, d); chk("R10 cnt", d, 32'h0);
        rd(2'd0, d); chk("R10 run bit", {31'h0, d[B_RUN]}, 32'h0);
        chk("R10 active", {31'h0, active_o}, 32'h0);
        wr(2'd0, ctl(3, 1, 1'b0, 1'b1, 1'b0));
        t0 = cyc;
        repeat (3) @(negedge clk);
        rd(2'd3, d); chk("R10 psc cleared a", d, 32'h0);
        @(negedge clk);
        rd(2'd3, d); chk("R10 psc cleared b", d, 32'h1);

        // R4 one-shot stops and stays stopped
        start(0, 1, 3, 1'b1, t0);
        repeat (6) @(negedge clk);
        rd(2'd0, d); chk("R4 run cleared", {31'h0, d[B_ACT]}, 32'h0);
        repeat (10) @(negedge clk);
        rd(2'd3, d); chk("R4 stays 0", d, 32'h0);
        chk("R4 flag", {31'h0, timeout_o}, 32'h1);

        // random mix: R3 R4 R5 R6 R7 R11 R12 R13
        for (int it = 0; it < 30; it++) begin
            int md  = int'($urandom_range(0, 3));
            int p   = int'($urandom_range(0, 3));
            int m   = int'($urandom_range(0, 9));
            bit ien = 1'($urandom_range(0, 1));
            int n   = int'($urandom_range(0, 60));
            int s, e, nn;
            bit f;
            tg0 = toggle_o;
            start(md, p, m, ien, t0);
            repeat (n) @(negedge clk);
            nn = cyc - t0;
            s = nn / (p + 1);
            e = meff(m);
            f = exp_flag(p, m, nn);
            rd(2'd3, d);
            chk("R12 R3 rnd count", d, 32'(exp_cnt(md, p, m, nn)));
            chk("R3 rnd flag", {31'h0, timeout_o}, {31'h0, f});
            chk("R11 rnd irq", {31'h0, irq_o}, {31'h0, f && ien});
            chk("R13 R4 rnd active", {31'h0, active_o},
                {31'h0, !(md == 0 && s >= e)});
            chk("R6 rnd toggle", {31'h0, toggle_o},
                {31'h0, 1'(tg0) ^ ((md == 2) ? 1'((s / e) % 2) : 1'b0)});
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule